// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns a stream of instruction bytes into one decoded record per instruction. Bytes arrive one per valid cycle on a simple valid/ready input. The block puts the 16-bit opcode together from the first two bytes, low byte first. It sorts the opcode into an operand class. When the class calls for operands, it reads the mode byte, which holds two 4-bit kind codes. It then collects the trailing operand bytes that each kind implies.

Each record carries the following fields:
- the start address of the instruction
- the opcode
- the class
- the two operand kinds
- the two operand values, zero-extended to 64 bits
- the total length in bytes
- an illegal flag

A bad opcode or a bad mode byte ends the instruction at once. Decoding then resumes with the next byte as a fresh opcode. An out-of-range register byte is flagged, but the rest of the instruction is still consumed, because its length is already known.

An execution stage downstream uses the records. Byte addresses count from a reset value `START_IP`, one per accepted byte.

Top module: `instr_decoder`

## Requirements
- R1: `byte_ready_o` is high out of reset and every byte with `byte_valid_i` high is accepted. `rec_valid_o` is high for exactly one cycle, the cycle after the final byte of an instruction is accepted. `rec_addr_o` gives the address of the instruction's first byte; the first byte after reset has address `START_IP`.
- R2: The first byte is the low byte of the opcode. Opcodes 0xF000, 0xF001, 0xF002, 0x3001 and 0x3005 produce class 0, length 2 and no illegal flag.
- R3: The class codes are as follows. Class 1 (destination then source) covers 0x1000 to 0x100C and 0x4000. Class 2 (two sources) covers 0x2000, 0x2001 and 0x3004. Class 3 (one source) covers 0x2002, 0x2003, 0x2004, 0x3000 and 0x3002. Class 4 (one destination) covers 0x3003. For classes 1 to 4 the third byte is the mode byte. Bits 7:4 give `rec_kind_a_o` and bits 3:0 give `rec_kind_b_o`, which is reported only for classes 1 and 2.
- R4: Kind codes and trailing byte counts are as follows. Kinds 0 to 3 are addresses and take 8 bytes. Kind 4 is a register and takes 1 byte. Kinds 5, 6, 7 and 8 are immediates and take 8, 4, 2 and 1 bytes. The operand A bytes come before the operand B bytes, and the length is 3 plus both counts.
- R5: Operand values are assembled least significant byte first and zero-extended to 64 bits. A register operand reports only bits 5:0 of its byte.
- R6: An immediate kind (5 to 8) in bits 7:4 of the mode byte for class 1 or class 4 makes the record illegal, with length 3.
- R7: An opcode not listed in R2 or R3 gives class 7, the illegal flag and length 2. The next byte is taken as the low byte of a new opcode.
- R8: A kind code of 9 to 15 in any position the class uses is illegal, with length 3. So is a nonzero bits 3:0 of the mode byte for class 3 or class 4.
- R9: A register byte with bit 7 or bit 6 set raises the illegal flag, while the full length of the instruction is still consumed.
- R10: Records of class 0 or class 7, and records ended by a rejected mode byte, report both kinds and both values as zero. Records of class 3 or class 4 report kind B and value B as zero.
- R11: Cycles with `byte_valid_i` low change neither the decode progress nor the byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Instruction byte present |
| byte_data_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Byte accepted when valid |
| rec_valid_o | output | 1 | Decoded record strobe |
| rec_addr_o | output | ADDR_W | Start address of the instruction |
| rec_opcode_o | output | 16 | Opcode |
| rec_class_o | output | 3 | Operand class code |
| rec_kind_a_o | output | 4 | First operand kind |
| rec_kind_b_o | output | 4 | Second operand kind |
| rec_val_a_o | output | 64 | First operand value |
| rec_val_b_o | output | 64 | Second operand value |
| rec_len_o | output | 5 | Instruction length in bytes |
| rec_illegal_o | output | 1 | Illegal instruction |

## Verification
The assertions hold the following on every cycle:
- the record strobe lasts a single cycle
- a no-operand record has length 2, and an unknown opcode is flagged at length 2
- a legal record's length matches its operand kinds
- a legal record never has an immediate in a destination position
- register and narrow immediate values carry no bits above their width

Only the bench scenarios can show the rest:
- the exact cycle of each record and its start address, across idle gaps
- the byte order of assembled values
- the recovery after each kind of illegal instruction
- the zeroing of unused fields

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int VAL_W = 64;
  localparam int LEN_W = 5;
  localparam logic [3:0] K_REG = 4'd4;

  typedef enum logic [2:0] {
    CL_NONE = 3'd0,
    CL_DS   = 3'd1,
    CL_SS   = 3'd2,
    CL_S    = 3'd3,
    CL_D    = 3'd4,
    CL_BAD  = 3'd7
  } cls_e;

  function automatic logic [3:0] kind_bytes(input logic [3:0] k);
    case (k)
      4'd0, 4'd1, 4'd2, 4'd3: return 4'd8;
      4'd4:                   return 4'd1;
      4'd5:                   return 4'd8;
      4'd6:                   return 4'd4;
      4'd7:                   return 4'd2;
      4'd8:                   return 4'd1;
      default:                return 4'd0;
    endcase
  endfunction

  function automatic logic kind_known(input logic [3:0] k);
    return k <= 4'd8;
  endfunction

  function automatic logic kind_imm(input logic [3:0] k);
    return (k >= 4'd5) && (k <= 4'd8);
  endfunction
endpackage

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  logic [15:0] opc_i,
  output cls_e        cls_o
);
  always_comb begin
    cls_o = CL_BAD;
    if (opc_i[15:4] == 12'h100 && opc_i[3:0] <= 4'hC) cls_o = CL_DS;
    else begin
      case (opc_i)
        16'h4000:                               cls_o = CL_DS;
        16'h2000, 16'h2001, 16'h3004:           cls_o = CL_SS;
        16'h2002, 16'h2003, 16'h2004,
        16'h3000, 16'h3002:                     cls_o = CL_S;
        16'h3003:                               cls_o = CL_D;
        16'hF000, 16'hF001, 16'hF002,
        16'h3001, 16'h3005:                     cls_o = CL_NONE;
        default:                                cls_o = CL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/idec_mode_chk.sv
module idec_mode_chk
  import idec_pkg::*;
(
  input  cls_e       cls_i,
  input  logic [7:0] mode_i,
  output logic       legal_o,
  output logic       two_o,
  output logic [3:0] nb_a_o,
  output logic [3:0] nb_b_o
);
  logic [3:0] hi, lo;
  assign hi = mode_i[7:4];
  assign lo = mode_i[3:0];

  always_comb begin
    case (cls_i)
      CL_DS:   legal_o = kind_known(hi) && !kind_imm(hi) && kind_known(lo);
      CL_SS:   legal_o = kind_known(hi) && kind_known(lo);
      CL_S:    legal_o = kind_known(hi) && (lo == 4'd0);
      CL_D:    legal_o = kind_known(hi) && !kind_imm(hi) && (lo == 4'd0);
      default: legal_o = 1'b0;
    endcase
  end

  assign two_o  = (cls_i == CL_DS) || (cls_i == CL_SS);
  assign nb_a_o = kind_bytes(hi);
  assign nb_b_o = kind_bytes(lo);
endmodule

// File: rtl/idec_slot.sv
module idec_slot #(
  parameter int VAL_W = 64,
  localparam int IDX_W = $clog2(VAL_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic             is_reg_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [VAL_W-1:0] val_o,
  output logic             bad_now_o
);
  logic [VAL_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else if (clr_i) val_q <= '0;
    else if (wr_i) begin
      if (is_reg_i) val_q <= {{(VAL_W-6){1'b0}}, byte_i[5:0]};
      else          val_q[{idx_i, 3'b000} +: 8] <= byte_i;
    end
  end

  assign val_o     = val_q;
  assign bad_now_o = wr_i && is_reg_i && (byte_i[7:6] != 2'b00);
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int                ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] START_IP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              rec_valid_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [15:0]       rec_opcode_o,
  output logic [2:0]        rec_class_o,
  output logic [3:0]        rec_kind_a_o,
  output logic [3:0]        rec_kind_b_o,
  output logic [63:0]       rec_val_a_o,
  output logic [63:0]       rec_val_b_o,
  output logic [4:0]        rec_len_o,
  output logic              rec_illegal_o
);
  localparam int IDX_W = $clog2(VAL_W / 8);

  typedef enum logic [2:0] {ST_OPLO, ST_OPHI, ST_MODE, ST_OPA, ST_OPB} st_e;

  st_e              st_q;
  logic [ADDR_W-1:0] pc_q, start_q;
  logic [7:0]       oplo_q;
  logic [15:0]      op_q;
  cls_e             cls_q, cls_now;
  logic [3:0]       kind_a_q, kind_b_q, nb_b_q, cnt_q;
  logic             two_q, bad_q, rec_v_q, ill_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] blen_q, len_q;

  logic             acc;
  logic [15:0]      opc_now;
  logic             m_legal, m_two;
  logic [3:0]       m_nb_a, m_nb_b;
  logic             a_bad_now, b_bad_now;
  logic [VAL_W-1:0] val_a, val_b;

  assign byte_ready_o = 1'b1;
  assign acc          = byte_valid_i;
  assign opc_now      = {byte_data_i, oplo_q};

  idec_classify u_cls (.opc_i(opc_now), .cls_o(cls_now));

  idec_mode_chk u_mode (
    .cls_i  (cls_q),
    .mode_i (byte_data_i),
    .legal_o(m_legal),
    .two_o  (m_two),
    .nb_a_o (m_nb_a),
    .nb_b_o (m_nb_b)
  );

  // operand A and B storage share one slot design
  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic             wr, bad_now;
    logic [VAL_W-1:0] val;
    assign wr = acc && (st_q == ((g == 0) ? ST_OPA : ST_OPB));
    idec_slot #(.VAL_W(VAL_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (acc && (st_q == ST_OPHI)),
      .wr_i     (wr),
      .is_reg_i (((g == 0) ? kind_a_q : kind_b_q) == K_REG),
      .idx_i    (idx_q),
      .byte_i   (byte_data_i),
      .val_o    (val),
      .bad_now_o(bad_now)
    );
  end
  assign val_a     = g_slot[0].val;
  assign val_b     = g_slot[1].val;
  assign a_bad_now = g_slot[0].bad_now;
  assign b_bad_now = g_slot[1].bad_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OPLO;
      pc_q     <= START_IP;
      start_q  <= START_IP;
      oplo_q   <= '0;
      op_q     <= '0;
      cls_q    <= CL_NONE;
      kind_a_q <= '0;
      kind_b_q <= '0;
      nb_b_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      two_q    <= 1'b0;
      bad_q    <= 1'b0;
      blen_q   <= '0;
      rec_v_q  <= 1'b0;
      len_q    <= '0;
      ill_q    <= 1'b0;
    end else begin
      rec_v_q <= 1'b0;
      if (acc) begin
        pc_q   <= pc_q + 1'b1;
        blen_q <= blen_q + 1'b1;
        unique case (st_q)
          ST_OPLO: begin
            start_q <= pc_q;
            oplo_q  <= byte_data_i;
            blen_q  <= LEN_W'(1);
            bad_q   <= 1'b0;
            st_q    <= ST_OPHI;
          end
          ST_OPHI: begin
            op_q     <= opc_now;
            cls_q    <= cls_now;
            kind_a_q <= '0;
            kind_b_q <= '0;
            if (cls_now == CL_NONE || cls_now == CL_BAD) begin
              rec_v_q <= 1'b1;
              len_q   <= blen_q + 1'b1;
              ill_q   <= (cls_now == CL_BAD);
              st_q    <= ST_OPLO;
            end else begin
              st_q <= ST_MODE;
            end
          end
          ST_MODE: begin
            if (!m_legal) begin
              rec_v_q <= 1'b1;
              len_q   <= blen_q + 1'b1;
              ill_q   <= 1'b1;
              st_q    <= ST_OPLO;
            end else begin
              kind_a_q <= byte_data_i[7:4];
              kind_b_q <= m_two ? byte_data_i[3:0] : 4'd0;
              two_q    <= m_two;
              nb_b_q   <= m_nb_b;
              cnt_q    <= m_nb_a - 4'd1;
              idx_q    <= '0;
              st_q     <= ST_OPA;
            end
          end
          ST_OPA: begin
            bad_q <= bad_q | a_bad_now;
            if (cnt_q == 4'd0) begin
              if (two_q) begin
                cnt_q <= nb_b_q - 4'd1;
                idx_q <= '0;
                st_q  <= ST_OPB;
              end else begin
                rec_v_q <= 1'b1;
                len_q   <= blen_q + 1'b1;
                ill_q   <= bad_q | a_bad_now;
                st_q    <= ST_OPLO;
              end
            end else begin
              cnt_q <= cnt_q - 4'd1;
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_OPB: begin
            if (cnt_q == 4'd0) begin
              rec_v_q <= 1'b1;
              len_q   <= blen_q + 1'b1;
              ill_q   <= bad_q | b_bad_now;
              st_q    <= ST_OPLO;
            end else begin
              cnt_q <= cnt_q - 4'd1;
              idx_q <= idx_q + 1'b1;
            end
          end
          default: st_q <= ST_OPLO;
        endcase
      end
    end
  end

  assign rec_valid_o   = rec_v_q;
  assign rec_addr_o    = start_q;
  assign rec_opcode_o  = op_q;
  assign rec_class_o   = cls_q;
  assign rec_kind_a_o  = kind_a_q;
  assign rec_kind_b_o  = kind_b_q;
  assign rec_val_a_o   = val_a;
  assign rec_val_b_o   = val_b;
  assign rec_len_o     = len_q;
  assign rec_illegal_o = ill_q;
endmodule

// File: rtl/idec_chk.sv
module idec_chk
  import idec_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rec_valid_o,
  input logic [2:0]  rec_class_o,
  input logic [3:0]  rec_kind_a_o,
  input logic [3:0]  rec_kind_b_o,
  input logic [63:0] rec_val_a_o,
  input logic [63:0] rec_val_b_o,
  input logic [4:0]  rec_len_o,
  input logic        rec_illegal_o
);
  logic legal_rec, two_rec, one_rec;
  assign legal_rec = rec_valid_o && !rec_illegal_o;
  assign two_rec   = (rec_class_o == 3'd1) || (rec_class_o == 3'd2);
  assign one_rec   = (rec_class_o == 3'd3) || (rec_class_o == 3'd4);

  AST_REC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o); // R1
  AST_NONE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_class_o == 3'd0) |-> (rec_len_o == 5'd2 && !rec_illegal_o)); // R2
  AST_BAD_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_class_o == 3'd7) |-> (rec_illegal_o && rec_len_o == 5'd2)); // R7
  AST_LEN_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_rec && two_rec) |->
      (rec_len_o == 5'd3 + {1'b0, kind_bytes(rec_kind_a_o)} + {1'b0, kind_bytes(rec_kind_b_o)})); // R4
  AST_LEN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_rec && one_rec) |->
      (rec_len_o == 5'd3 + {1'b0, kind_bytes(rec_kind_a_o)} && rec_kind_b_o == 4'd0 && rec_val_b_o == 64'd0)); // R10
  AST_DEST_NO_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_rec && (rec_class_o == 3'd1 || rec_class_o == 3'd4)) |-> !kind_imm(rec_kind_a_o)); // R6
  AST_REG_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_kind_a_o == K_REG) |-> (rec_val_a_o[63:6] == '0)); // R5
  AST_IMM8_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_rec && rec_kind_b_o == 4'd8) |-> (rec_val_b_o[63:8] == '0)); // R5
endmodule

bind instr_decoder idec_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rec_valid_o  (rec_valid_o),
  .rec_class_o  (rec_class_o),
  .rec_kind_a_o (rec_kind_a_o),
  .rec_kind_b_o (rec_kind_b_o),
  .rec_val_a_o  (rec_val_a_o),
  .rec_val_b_o  (rec_val_b_o),
  .rec_len_o    (rec_len_o),
  .rec_illegal_o(rec_illegal_o)
);

// File: tb/instr_decoder_test.sv
module instr_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] IP0 = 64'h100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_ready_o, rec_valid_o, rec_illegal_o;
  logic [63:0] rec_addr_o, rec_val_a_o, rec_val_b_o;
  logic [15:0] rec_opcode_o;
  logic [2:0]  rec_class_o;
  logic [3:0]  rec_kind_a_o, rec_kind_b_o;
  logic [4:0]  rec_len_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  instr_decoder #(.ADDR_W(64), .START_IP(IP0)) uut (
    .clk_i, .rst_ni, .byte_valid_i, .byte_data_i, .byte_ready_o,
    .rec_valid_o, .rec_addr_o, .rec_opcode_o, .rec_class_o,
    .rec_kind_a_o, .rec_kind_b_o, .rec_val_a_o, .rec_val_b_o,
    .rec_len_o, .rec_illegal_o
  );

  typedef struct {
    string       tag;
    logic [63:0] addr;
    logic [15:0] opc;
    int          cls;
    int          ka, kb;
    logic [63:0] va, vb;
    int          len;
    bit          ill;
  } rec_t;

  rec_t        exp_q[$];
  logic [7:0]  byte_q[$];
  bit          last_q[$];
  logic [63:0] nxt = IP0;
  int          total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic int tb_cls(input logic [15:0] o);
    if ((o >= 16'h1000 && o <= 16'h100C) || o == 16'h4000) return 1;
    if (o == 16'h2000 || o == 16'h2001 || o == 16'h3004) return 2;
    if (o == 16'h2002 || o == 16'h2003 || o == 16'h2004 || o == 16'h3000 || o == 16'h3002) return 3;
    if (o == 16'h3003) return 4;
    if (o == 16'hF000 || o == 16'hF001 || o == 16'hF002 || o == 16'h3001 || o == 16'h3005) return 0;
    return 7;
  endfunction

  function automatic int tb_nb(input int k);
    int tbl[9] = '{8, 8, 8, 8, 1, 8, 4, 2, 1};
    return (k >= 0 && k <= 8) ? tbl[k] : 0;
  endfunction

  function automatic bit is_imm(input int k);
    return k >= 5 && k <= 8;
  endfunction

  task automatic put_opnd(input int k, input logic [63:0] v, inout logic [7:0] bs[$],
                          output logic [63:0] ev, inout bit ill);
    if (k == 4) begin
      bs.push_back(v[7:0]);
      ev = {58'd0, v[5:0]};
      if (v[7:6] != 2'b00) ill = 1;
    end else begin
      ev = '0;
      for (int i = 0; i < tb_nb(k); i++) begin
        bs.push_back(v[8*i +: 8]);
        ev[8*i +: 8] = v[8*i +: 8];
      end
    end
  endtask

  task automatic add(input string tag, input logic [15:0] opc, input logic [7:0] mode,
                     input logic [63:0] va, input logic [63:0] vb);
    rec_t r;
    logic [7:0] bs[$];
    int hi, lo;
    bit ok;
    r.tag = tag; r.addr = nxt; r.opc = opc; r.cls = tb_cls(opc);
    r.ka = 0; r.kb = 0; r.va = '0; r.vb = '0; r.ill = 0;
    bs.push_back(opc[7:0]);
    bs.push_back(opc[15:8]);
    if (r.cls == 7) r.ill = 1;
    else if (r.cls != 0) begin
      bs.push_back(mode);
      hi = int'(mode[7:4]); lo = int'(mode[3:0]);
      case (r.cls)
        1: ok = hi <= 8 && !is_imm(hi) && lo <= 8;
        2: ok = hi <= 8 && lo <= 8;
        3: ok = hi <= 8 && lo == 0;
        default: ok = hi <= 8 && !is_imm(hi) && lo == 0;
      endcase
      if (!ok) r.ill = 1;
      else begin
        r.ka = hi;
        put_opnd(hi, va, bs, r.va, r.ill);
        if (r.cls <= 2) begin
          r.kb = lo;
          put_opnd(lo, vb, bs, r.vb, r.ill);
        end
      end
    end
    r.len = bs.size();
    nxt += 64'(r.len);
    foreach (bs[i]) begin
      byte_q.push_back(bs[i]);
      last_q.push_back(i == bs.size() - 1);
    end
    exp_q.push_back(r);
  endtask

  task automatic cmp_rec(input rec_t r);
    chk(rec_addr_o == r.addr, r.tag, "addr", rec_addr_o, r.addr);
    chk(rec_opcode_o == r.opc, r.tag, "opcode", 64'(rec_opcode_o), 64'(r.opc));
    chk(int'(rec_class_o) == r.cls, r.tag, "class", 64'(rec_class_o), 64'(r.cls));
    chk(int'(rec_len_o) == r.len, r.tag, "len", 64'(rec_len_o), 64'(r.len));
    chk(rec_illegal_o == r.ill, r.tag, "illegal", 64'(rec_illegal_o), 64'(r.ill));
    chk(int'(rec_kind_a_o) == r.ka, r.tag, "kind_a", 64'(rec_kind_a_o), 64'(r.ka));
    chk(int'(rec_kind_b_o) == r.kb, r.tag, "kind_b", 64'(rec_kind_b_o), 64'(r.kb));
    chk(rec_val_a_o == r.va, r.tag, "val_a", rec_val_a_o, r.va);
    chk(rec_val_b_o == r.vb, r.tag, "val_b", rec_val_b_o, r.vb);
  endtask

  initial begin
    bit pend = 0;
    int cyc = 0;
    rec_t r;
    // R2 zero-operand set
    add("R2", 16'hF001, 8'h00, 0, 0);
    add("R2", 16'hF000, 8'h00, 0, 0);
    add("R2", 16'h3001, 8'h00, 0, 0);
    add("R2", 16'h3005, 8'h00, 0, 0);
    add("R2", 16'hF002, 8'h00, 0, 0);
    // R3 / R4 / R5 legal forms
    add("R3", 16'h1000, 8'h45, 64'h03, 64'h1122_3344_5566_7788);
    add("R4", 16'h4000, 8'h08, 64'hA0A1_A2A3_A4A5_A6A7, 64'hFFFF_FFFF_FFFF_FF5A);
    add("R5", 16'h2000, 8'h76, 64'hDEAD_BEEF_0000_1234, 64'h9999_8888_7777_6666);
    add("R4", 16'h3004, 8'h85, 64'h80, 64'h0102_0304_0506_0708);
    add("R10", 16'h2002, 8'h60, 64'hCAFE_F00D, 0);
    add("R3", 16'h3003, 8'h40, 64'h1F, 0);
    add("R4", 16'h3002, 8'h20, 64'h0000_0000_0000_4321, 0);
    add("R11", 16'h3000, 8'h40, 64'h3F, 0);
    add("R3", 16'h100C, 8'h34, 64'h0F0E_0D0C_0B0A_0908, 64'h2A);
    // illegal forms
    add("R7", 16'h5000, 8'h00, 0, 0);
    add("R7", 16'h100D, 8'h00, 0, 0);
    add("R6", 16'h1001, 8'h54, 0, 0);
    add("R6", 16'h3003, 8'h80, 0, 0);
    add("R8", 16'h2003, 8'h51, 0, 0);
    add("R8", 16'h2001, 8'h49, 0, 0);
    add("R8", 16'h1002, 8'hA4, 0, 0);
    add("R9", 16'h1005, 8'h44, 64'hC5, 64'h03);
    add("R9", 16'h2004, 8'h40, 64'h41, 0);
    add("R2", 16'hF001, 8'h00, 0, 0);

    repeat (3) @(negedge clk_i);
    chk(rec_valid_o == 1'b0, "R1", "reset valid", 64'(rec_valid_o), 0);
    chk(byte_ready_o == 1'b1, "R1", "reset ready", 64'(byte_ready_o), 1);
    rst_ni = 1'b1;

    while (byte_q.size() > 0 || pend) begin
      @(negedge clk_i);
      cyc++;
      if (cyc > 5000) begin
        chk(1'b0, "R1", "watchdog", 64'(cyc), 0);
        break;
      end
      chk(rec_valid_o == pend, "R1", "valid timing", 64'(rec_valid_o), 64'(pend));
      chk(byte_ready_o == 1'b1, "R1", "ready", 64'(byte_ready_o), 1);
      if (pend && rec_valid_o) begin
        r = exp_q.pop_front();
        cmp_rec(r);
      end
      // R11: periodic idle cycles
      if (byte_q.size() > 0 && (cyc % 5) != 3) begin
        byte_valid_i = 1'b1;
        byte_data_i  = byte_q.pop_front();
        pend         = last_q.pop_front();
      end else begin
        byte_valid_i = 1'b0;
        byte_data_i  = 8'hEE;
        pend         = 0;
      end
    end
    byte_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(rec_valid_o == 1'b0, "R1", "idle valid", 64'(rec_valid_o), 0);
    chk(exp_q.size() == 0, "R1", "records left", 64'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule